// File: doc/BRIEF.md
# PAM4 Termination-Symbol Frame Synchronizer

This receive-side block takes one sliced 2-bit PAM4 symbol per clock and finds two alignments in that stream. A row is a fixed number of symbols, and its last symbol is a termination symbol that is always sent at one of the two outer levels. The block first searches for that symbol phase. It tests one candidate position per row. If the candidate fails, it moves the candidate one symbol later and tests again. It declares row lock once the candidate has passed a run of consecutive rows.

With row lock held, the block looks for the frame boundary. A frame is a fixed number of rows. The first symbols of its first row carry a known overhead field, which is supplied on an input so it can be configured. The frame search follows the same hunt-and-confirm pattern as the row search, but it moves one whole row at a time.

The outputs describe the symbol currently on `sym_in`. They are the two lock flags, a row-start strobe, a frame-start strobe, and a data-valid flag that is low on termination and overhead symbols. The downstream deframer uses that flag as its payload mask.

Top module: `pam4_tframe_sync`

## Requirements
- R1: While reset is asserted and right after it, term_lock, frame_lock, row_start, frame_start and data_ok are all 0, and the first symbol after reset is taken as row position 0.
- R2: A termination slot is valid when the symbol code has bit 0 clear, so codes 2'b10 and 2'b00 pass and 2'b11 and 2'b01 fail. After 64 consecutive valid slots, term_lock goes high on the symbol that follows the 64th slot.
- R3: While hunting, every failed slot moves the candidate termination position one symbol later. Once locked, row_start marks the symbol right after each termination symbol.
- R4: When locked, slots are counted in 64-slot windows that start at lock. The 16th invalid slot inside one window clears term_lock from the next symbol on. A window that holds only 15 invalid slots keeps the lock.
- R5: The overhead field is checked only while term_lock is high. It is made of symbols 0 and 1 of row 0: symbol 0 is compared with hdr_pat[3:2] and symbol 1 with hdr_pat[1:0]. While frame lock is being hunted, each mismatch moves the candidate frame start one row later.
- R6: frame_lock goes high after 4 consecutive matching overhead fields, starting at symbol 2 of the row that held the 4th match.
- R7: frame_lock clears after 3 consecutive mismatching fields, starting at symbol 2 of the row that held the 3rd mismatch. A match in between restarts the miss count. frame_lock also clears whenever term_lock clears.
- R8: Frames are 88 rows of 32 symbols. frame_start is high only on symbol 0 of row 0 while frame_lock is high, and every frame_start coincides with row_start.
- R9: data_ok is high only while term_lock is high. It is low on symbol 31 of every row and, while frame_lock is high, on symbols 0 and 1 of row 0.
- R10: hdr_pat sets the overhead field that is searched for. A stream carrying any other field never reaches frame lock, and a change of hdr_pat takes effect on the next overhead field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one symbol per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_in | input | 2 | Sliced PAM4 symbol code |
| hdr_pat | input | 4 | Expected overhead field, first symbol in the upper bits |
| term_lock | output | 1 | Termination phase locked |
| frame_lock | output | 1 | Frame boundary locked |
| row_start | output | 1 | Current symbol is the first of a row |
| frame_start | output | 1 | Current symbol is the first of a frame |
| data_ok | output | 1 | Current symbol carries payload |

## Verification
If the symbol-position counter is wrong, row_start and data_ok fall out of step with the stream's termination symbols within 32 symbols. A miscounted hunt or window counter moves the edge of term_lock to a different symbol, and the directed streams pin that edge to an exact symbol. A row index that is wrong, or a frame hunt that slips badly, puts frame_start on the wrong symbol or moves the rise or fall of frame_lock by whole rows. That shows up within one 2816-symbol frame. The bench drives streams with a known phase, so each lock edge and each mask bit has an exact expected symbol index.

// File: rtl/pam4_sync_pkg.sv
package pam4_sync_pkg;

   typedef logic [1:0] pam4_sym_t;

   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_LOCK = 1'b1
   } lock_st_e;

   // outer PAM4 levels carry codes 10 and 00: bit 0 clear
   function automatic logic is_outer(input pam4_sym_t s);
      return (s[0] == 1'b0);
   endfunction

endpackage

// File: rtl/pam4_slot_hunt.sv
module pam4_slot_hunt
   import pam4_sync_pkg::*;
#(
   parameter int ROW_SYMS   = 32,
   parameter int GOOD_SLOTS = 64,
   parameter int BAD_LIMIT  = 16,
   parameter int WIN_SLOTS  = 64,
   parameter int POS_W      = $clog2(ROW_SYMS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pam4_sym_t        sym_i,
   output logic [POS_W-1:0] pos_o,
   output logic             lock_o,
   output logic             drop_o
);

   localparam int GOOD_W = $clog2(GOOD_SLOTS);
   localparam int WIN_W  = $clog2(WIN_SLOTS);
   localparam int BAD_W  = $clog2(BAD_LIMIT);
   localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(ROW_SYMS - 1);
   localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(GOOD_SLOTS - 1);
   localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_SLOTS - 1);
   localparam logic [BAD_W-1:0]  BAD_LAST  = BAD_W'(BAD_LIMIT - 1);

   lock_st_e          st_q;
   logic [POS_W-1:0]  pos_q;
   logic [GOOD_W-1:0] good_q;
   logic [WIN_W-1:0]  win_q;
   logic [BAD_W-1:0]  bad_q;
   logic              at_slot;
   logic              slot_ok;
   logic              hunt_slip;
   logic              lose;

   always_comb begin
      at_slot   = (pos_q == POS_LAST);
      slot_ok   = is_outer(sym_i);
      hunt_slip = at_slot && !slot_ok && (st_q == ST_HUNT);
      lose      = at_slot && !slot_ok && (st_q == ST_LOCK) && (bad_q == BAD_LAST);
   end

   // symbol position inside the row; a failed candidate holds the last
   // position for one more symbol, shifting the tested phase by one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (at_slot) begin
         pos_q <= hunt_slip ? pos_q : '0;
      end else begin
         pos_q <= pos_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_HUNT;
         good_q <= '0;
         win_q  <= '0;
         bad_q  <= '0;
      end else if (at_slot) begin
         case (st_q)
            ST_HUNT: begin
               if (!slot_ok) begin
                  good_q <= '0;
               end else if (good_q == GOOD_LAST) begin
                  st_q   <= ST_LOCK;
                  good_q <= '0;
                  win_q  <= '0;
                  bad_q  <= '0;
               end else begin
                  good_q <= good_q + 1'b1;
               end
            end
            ST_LOCK: begin
               if (lose) begin
                  st_q   <= ST_HUNT;
                  good_q <= '0;
               end else if (win_q == WIN_LAST) begin
                  win_q <= '0;
                  bad_q <= '0;
               end else begin
                  win_q <= win_q + 1'b1;
                  if (!slot_ok) bad_q <= bad_q + 1'b1;
               end
            end
            default: st_q <= ST_HUNT;
         endcase
      end
   end

   assign pos_o  = pos_q;
   assign lock_o = (st_q == ST_LOCK);
   assign drop_o = lose;

   assert_lock_at_row_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> (pos_q == '0));

   assert_slip_holds_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_slip |=> (pos_q == POS_LAST));

   assert_loss_after_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_o) |-> ($past(bad_q) == BAD_LAST));

endmodule

// File: rtl/pam4_frame_hunt.sv
module pam4_frame_hunt
   import pam4_sync_pkg::*;
#(
   parameter int ROW_SYMS   = 32,
   parameter int FRAME_ROWS = 88,
   parameter int HDR_SYMS   = 2,
   parameter int MATCH_NEED = 4,
   parameter int MISS_LIMIT = 3,
   parameter int POS_W      = $clog2(ROW_SYMS),
   parameter int ROW_W      = $clog2(FRAME_ROWS),
   parameter int PAT_W      = 2 * HDR_SYMS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pam4_sym_t        sym_i,
   input  logic [POS_W-1:0] pos_i,
   input  logic             tlock_i,
   input  logic             tdrop_i,
   input  logic [PAT_W-1:0] pat_i,
   output logic [ROW_W-1:0] row_o,
   output logic             lock_o
);

   localparam int CNT_MAX = (MATCH_NEED > MISS_LIMIT) ? MATCH_NEED : MISS_LIMIT;
   localparam int CNT_W   = $clog2(CNT_MAX);
   localparam logic [POS_W-1:0] POS_LAST   = POS_W'(ROW_SYMS - 1);
   localparam logic [POS_W-1:0] HDR_END    = POS_W'(HDR_SYMS - 1);
   localparam logic [POS_W-1:0] HDR_LEN    = POS_W'(HDR_SYMS);
   localparam logic [ROW_W-1:0] ROW_LAST   = ROW_W'(FRAME_ROWS - 1);
   localparam logic [CNT_W-1:0] MATCH_LAST = CNT_W'(MATCH_NEED - 1);
   localparam logic [CNT_W-1:0] MISS_LAST  = CNT_W'(MISS_LIMIT - 1);

   lock_st_e         st_q;
   logic [ROW_W-1:0] row_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PAT_W-1:0] field;
   logic             in_hdr;
   logic             at_eval;
   logic             hit;
   logic             row_end;
   logic             clear;

   always_comb begin
      in_hdr  = (row_q == '0) && (pos_i < HDR_LEN);
      at_eval = tlock_i && !tdrop_i && (row_q == '0) && (pos_i == HDR_END);
      row_end = (pos_i == POS_LAST);
      clear   = !tlock_i || tdrop_i;
   end

   // the overhead field is gathered symbol by symbol; a one-symbol field
   // needs no capture register
   generate
      if (HDR_SYMS == 1) begin : g_single
         assign field = sym_i;
      end else begin : g_multi
         logic [PAT_W-3:0] cap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cap_q <= '0;
            else if (in_hdr) cap_q <= field[PAT_W-3:0];
         end
         assign field = {cap_q, sym_i};
      end
   endgenerate

   assign hit = (field == pat_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
         st_q  <= ST_HUNT;
         cnt_q <= '0;
      end else if (clear) begin
         row_q <= '0;
         st_q  <= ST_HUNT;
         cnt_q <= '0;
      end else begin
         if (at_eval && !hit && (st_q == ST_HUNT)) begin
            row_q <= ROW_LAST;
         end else if (row_end) begin
            row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
         end
         if (at_eval) begin
            case (st_q)
               ST_HUNT: begin
                  if (!hit) begin
                     cnt_q <= '0;
                  end else if (cnt_q == MATCH_LAST) begin
                     st_q  <= ST_LOCK;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_LOCK: begin
                  if (hit) begin
                     cnt_q <= '0;
                  end else if (cnt_q == MISS_LAST) begin
                     st_q  <= ST_HUNT;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: st_q <= ST_HUNT;
            endcase
         end
      end
   end

   assign row_o  = row_q;
   assign lock_o = (st_q == ST_LOCK);

   assert_frame_needs_row_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |-> tlock_i);

   assert_frame_lock_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> ((pos_i == HDR_LEN) && (row_q == '0)));

   assert_frame_lock_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lock_o) && tlock_i) |-> $past(at_eval && !hit));

   assert_row_index_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      row_q <= ROW_LAST);

endmodule

// File: rtl/pam4_sync_mask.sv
module pam4_sync_mask #(
   parameter int ROW_SYMS   = 32,
   parameter int FRAME_ROWS = 88,
   parameter int HDR_SYMS   = 2,
   parameter int POS_W      = $clog2(ROW_SYMS),
   parameter int ROW_W      = $clog2(FRAME_ROWS)
) (
   input  logic [POS_W-1:0] pos_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic             tlock_i,
   input  logic             flock_i,
   output logic             row_start_o,
   output logic             frame_start_o,
   output logic             data_ok_o
);

   localparam logic [POS_W-1:0] POS_LAST = POS_W'(ROW_SYMS - 1);
   localparam logic [POS_W-1:0] HDR_LEN  = POS_W'(HDR_SYMS);

   logic head;
   logic first_row;
   logic ovh;
   logic term;

   always_comb begin
      head          = (pos_i == '0);
      first_row     = (row_i == '0);
      term          = (pos_i == POS_LAST);
      ovh           = flock_i && first_row && (pos_i < HDR_LEN);
      row_start_o   = tlock_i && head;
      frame_start_o = flock_i && first_row && head;
      data_ok_o     = tlock_i && !term && !ovh;
   end

endmodule

// File: rtl/pam4_tframe_sync.sv
module pam4_tframe_sync
   import pam4_sync_pkg::*;
#(
   parameter int ROW_SYMS   = 32,
   parameter int FRAME_ROWS = 88,
   parameter int HDR_SYMS   = 2,
   parameter int GOOD_SLOTS = 64,
   parameter int BAD_LIMIT  = 16,
   parameter int WIN_SLOTS  = 64,
   parameter int MATCH_NEED = 4,
   parameter int MISS_LIMIT = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            sym_in,
   input  logic [2*HDR_SYMS-1:0] hdr_pat,
   output logic                  term_lock,
   output logic                  frame_lock,
   output logic                  row_start,
   output logic                  frame_start,
   output logic                  data_ok
);

   localparam int POS_W = $clog2(ROW_SYMS);
   localparam int ROW_W = $clog2(FRAME_ROWS);
   localparam int PAT_W = 2 * HDR_SYMS;

   generate
      if (ROW_SYMS < 4) begin : g_chk_row
         $error("row length too short");
      end
      if ((HDR_SYMS < 1) || (HDR_SYMS > ROW_SYMS - 2)) begin : g_chk_hdr
         $error("overhead field must fit before the termination symbol");
      end
      if (FRAME_ROWS < 2) begin : g_chk_frame
         $error("frame needs at least two rows");
      end
      if ((GOOD_SLOTS < 2) || (BAD_LIMIT < 2) || (WIN_SLOTS < BAD_LIMIT)) begin : g_chk_tlock
         $error("termination lock thresholds out of range");
      end
      if ((MATCH_NEED < 2) || (MISS_LIMIT < 2)) begin : g_chk_flock
         $error("frame lock thresholds out of range");
      end
   endgenerate

   logic [POS_W-1:0] pos;
   logic [ROW_W-1:0] row;
   logic             tdrop;

   pam4_slot_hunt #(
      .ROW_SYMS   (ROW_SYMS),
      .GOOD_SLOTS (GOOD_SLOTS),
      .BAD_LIMIT  (BAD_LIMIT),
      .WIN_SLOTS  (WIN_SLOTS),
      .POS_W      (POS_W)
   ) slot_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .sym_i  (sym_in),
      .pos_o  (pos),
      .lock_o (term_lock),
      .drop_o (tdrop)
   );

   pam4_frame_hunt #(
      .ROW_SYMS   (ROW_SYMS),
      .FRAME_ROWS (FRAME_ROWS),
      .HDR_SYMS   (HDR_SYMS),
      .MATCH_NEED (MATCH_NEED),
      .MISS_LIMIT (MISS_LIMIT),
      .POS_W      (POS_W),
      .ROW_W      (ROW_W),
      .PAT_W      (PAT_W)
   ) frame_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sym_i   (sym_in),
      .pos_i   (pos),
      .tlock_i (term_lock),
      .tdrop_i (tdrop),
      .pat_i   (hdr_pat),
      .row_o   (row),
      .lock_o  (frame_lock)
   );

   pam4_sync_mask #(
      .ROW_SYMS   (ROW_SYMS),
      .FRAME_ROWS (FRAME_ROWS),
      .HDR_SYMS   (HDR_SYMS),
      .POS_W      (POS_W),
      .ROW_W      (ROW_W)
   ) mask_i (
      .pos_i         (pos),
      .row_i         (row),
      .tlock_i       (term_lock),
      .flock_i       (frame_lock),
      .row_start_o   (row_start),
      .frame_start_o (frame_start),
      .data_ok_o     (data_ok)
   );

   assert_frame_head_on_row_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> row_start);

   assert_frame_head_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> !data_ok);

endmodule

// File: tb/pam4_tframe_sync_tb_top.sv
`timescale 1ns/1ps
module pam4_tframe_sync_tb_top;

   localparam int ROWLEN = 32;
   localparam int FRMLEN = 32 * 88;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sym_in = 2'b00;
   logic [3:0] hdr_pat = 4'b1001;
   logic       term_lock, frame_lock, row_start, frame_start, data_ok;

   int          n_chk = 0;
   int          n_fail = 0;
   int          sidx = 0;
   logic [3:0]  ovh_pat = 4'b1001;
   int          bad_lo = -1;
   int          bad_hi = -1;
   logic [31:0] ovh_bad_mask = '0;
   logic [15:0] lfsr = 16'hACE1;
   logic        o_tl, o_fl, o_rs, o_fs, o_ok;

   always #10 clk = ~clk;

   pam4_tframe_sync dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sym_in      (sym_in),
      .hdr_pat     (hdr_pat),
      .term_lock   (term_lock),
      .frame_lock  (frame_lock),
      .row_start   (row_start),
      .frame_start (frame_start),
      .data_ok     (data_ok)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (symbol %0d)", req, what, act, exp, sidx);
      end
   endtask

   task automatic do_reset(input int start);
      rst_n = 1'b0;
      sym_in = 2'b00;
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      sidx = start;
   endtask

   // drive one stream symbol, sample outputs for it, advance past the edge
   task automatic next_sym();
      int rp = sidx % ROWLEN;
      int ra = sidx / ROWLEN;
      int rw = ra % 88;
      int fa = sidx / FRMLEN;
      logic [1:0] s;
      if (rp == ROWLEN - 1) begin
         if (ra >= bad_lo && ra <= bad_hi) s = (ra % 2 == 1) ? 2'b11 : 2'b01;
         else                              s = (ra % 2 == 1) ? 2'b10 : 2'b00;
      end else if (rw == 0 && rp < 2) begin
         if (fa < 32 && ovh_bad_mask[fa]) s = 2'b00;
         else s = (rp == 0) ? ovh_pat[3:2] : ovh_pat[1:0];
      end else begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         s = {lfsr[0], 1'b1};
      end
      sym_in = s;
      #1;
      o_tl = term_lock; o_fl = frame_lock; o_rs = row_start;
      o_fs = frame_start; o_ok = data_ok;
      @(posedge clk);
      #2;
      sidx++;
   endtask

   task automatic run_to(input int last);
      while (sidx <= last) next_sym();
   endtask

   // R1, R2, R8: reset state and exact lock symbol with aligned stream
   task automatic t_reset_lock();
      int early = 0;
      bad_lo = -1; bad_hi = -1; ovh_bad_mask = '0;
      ovh_pat = 4'b1001; hdr_pat = 4'b1001;
      rst_n = 1'b0;
      #3;
      chk("R1", "term_lock in reset", int'(term_lock), 0);
      chk("R1", "outputs in reset", int'({frame_lock, row_start, frame_start, data_ok}), 0);
      do_reset(0);
      #1;
      chk("R1", "outputs after reset", int'({term_lock, frame_lock, row_start, frame_start, data_ok}), 0);
      while (sidx < 2047) begin
         next_sym();
         if (o_tl || o_ok || o_rs) early++;
      end
      chk("R2", "lock or mask before 64 good slots", early, 0);
      next_sym();
      chk("R2", "term_lock on 64th slot", int'(o_tl), 0);
      next_sym();
      chk("R2", "term_lock after 64th slot", int'(o_tl), 1);
      chk("R8", "row_start at first locked symbol", int'(o_rs), 1);
   endtask

   // R3: misaligned start, candidate slips one symbol per failure
   task automatic t_hunt_offset();
      int first = -1;
      int bad = 0;
      do_reset(13);
      while (sidx < 2300) begin
         int rp = sidx % ROWLEN;
         int me = sidx;
         next_sym();
         if (o_tl && first < 0) first = me;
         if (o_tl && (int'(o_rs) != int'(rp == 0))) bad++;
      end
      chk("R3", "first locked symbol after slips", first, 2080);
      chk("R3", "row_start phase after slips", bad, 0);
   endtask

   // R4: 15 bad slots in a window keep lock, 16 lose it
   task automatic t_loss();
      do_reset(0);
      bad_lo = 64; bad_hi = 78;
      run_to(4095);
      chk("R4", "lock after 15 bad slots in window", int'(o_tl), 1);
      next_sym();
      chk("R4", "lock at next window start", int'(o_tl), 1);
      bad_lo = 128; bad_hi = 143;
      run_to(4607);
      chk("R4", "lock on 16th bad slot", int'(o_tl), 1);
      next_sym();
      chk("R4", "lock after 16th bad slot", int'(o_tl), 0);
      chk("R4", "row_start after loss", int'(o_rs), 0);
      bad_lo = -1; bad_hi = -1;
   endtask

   // R5, R6, R8, R9: frame lock timing and payload mask
   task automatic t_frame();
      int e_ok = 0, e_rs = 0, e_fs = 0;
      do_reset(0);
      ovh_pat = 4'b1001; hdr_pat = 4'b1001; ovh_bad_mask = '0;
      run_to(4 * FRMLEN + 1);
      chk("R5", "no frame lock from pre-lock field", int'(o_fl), 0);
      chk("R6", "frame_lock on 4th match symbol", int'(o_fl), 0);
      next_sym();
      chk("R6", "frame_lock after 4th match", int'(o_fl), 1);
      run_to(5 * FRMLEN - 1);
      next_sym();
      chk("R8", "frame_start at frame head", int'(o_fs), 1);
      chk("R9", "data_ok at frame head", int'(o_ok), 0);
      while (sidx < 6 * FRMLEN) begin
         int rp = sidx % ROWLEN;
         int rw = (sidx / ROWLEN) % 88;
         next_sym();
         if (int'(o_ok) != int'(rp != 31 && !(rw == 0 && rp < 2))) e_ok++;
         if (int'(o_rs) != int'(rp == 0)) e_rs++;
         if (int'(o_fs) != int'(rp == 0 && rw == 0)) e_fs++;
      end
      chk("R9", "data_ok mismatches over one frame", e_ok, 0);
      chk("R8", "row_start mismatches over one frame", e_rs, 0);
      chk("R8", "frame_start mismatches over one frame", e_fs, 0);
   endtask

   // R7: two misses then a hit keep lock, three misses drop it
   task automatic t_frame_loss();
      ovh_bad_mask = 32'h0000_0EC0;
      run_to(9 * FRMLEN + 1);
      chk("R7", "lock after miss, miss, hit, miss", int'(o_fl), 1);
      run_to(11 * FRMLEN + 1);
      chk("R7", "lock on 3rd consecutive miss", int'(o_fl), 1);
      next_sym();
      chk("R7", "lock after 3rd consecutive miss", int'(o_fl), 0);
      chk("R7", "row lock kept", int'(o_tl), 1);
      ovh_bad_mask = '0;
   endtask

   // R10: configured field decides which stream locks
   task automatic t_pattern();
      int seen = 0;
      do_reset(0);
      ovh_pat = 4'b0010; hdr_pat = 4'b1001; ovh_bad_mask = '0;
      while (sidx < 7 * FRMLEN) begin
         next_sym();
         if (o_fl) seen++;
      end
      chk("R10", "frame lock with foreign field", seen, 0);
      chk("R10", "row lock held", int'(o_tl), 1);
      hdr_pat = 4'b0010;
      run_to(10 * FRMLEN + 1);
      chk("R10", "frame_lock on 4th match of new field", int'(o_fl), 0);
      next_sym();
      chk("R10", "frame_lock after new field", int'(o_fl), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset_lock();
      t_hunt_offset();
      t_loss();
      t_frame();
      t_frame_loss();
      t_pattern();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule